// File: doc/BRIEF.md
# RC Servo Pulse to PWM Converter

This block turns the pulse train of a hobby radio-control servo channel into a proportional PWM output. It synchronises the incoming servo line and times each high pulse in ticks of a programmable prescaler. The measured width is held inside the legal servo window, which runs from 920 µs to 2120 µs with neutral at 1520 µs. It is then rescaled linearly to an 8-bit duty value, so that the low end of the window gives 0 and the high end gives 255.

The duty value drives a symmetric up/down-counting PWM generator. Its output spans the whole range from fully off to fully on. A new duty value reaches the generator only at a turning point of its counter. While a measurement is being converted, the input is not watched, so pulses in that window have no effect. If a pulse stays high so long that the width counter saturates, the measurement is dropped and the previous duty value remains in force. A debug port shows the latest duty value and a one-cycle strobe each time a new one is produced.

Top module: `servo_pwm_top`

## Requirements
- R1: After reset, dutyOut is 0, dutyValid is low and pwmOut stays low.
- R2: A pulse that is high for N clock cycles on servoIn measures floor(N / TICK_DIV) ticks. The two synchroniser flops delay the rising and falling edges by the same amount, so that delay does not change the measured width.
- R3: A measured width below MIN_TICKS is treated as MIN_TICKS, which gives a duty of 0.
- R4: A measured width above MAX_TICKS is treated as MAX_TICKS, which gives a duty of 255.
- R5: For a width w inside the window, the duty is floor((w − MIN_TICKS) × 255 / (MAX_TICKS − MIN_TICKS)).
- R6: Each accepted measurement raises dutyValid for exactly one cycle, with the new value on dutyOut. dutyOut does not change at any other time.
- R7: From the falling edge of a measured pulse until its duty value is produced, rising and falling edges on servoIn are ignored. A pulse that lies wholly inside that window produces no dutyValid and does not change dutyOut.
- R8: If servoIn stays high until the width counter reaches its all-ones value (2^CNT_W − 1 ticks), the measurement is discarded. No dutyValid follows, dutyOut keeps its value, and the block waits for a fresh rising edge.
- R9: The PWM counter runs 0, 1, …, 255, 254, …, 1 and repeats, a period of 510 cycles. In any 510 consecutive cycles with a stable compare value D, pwmOut is high for 0 cycles when D = 0, for 510 cycles when D = 255, and otherwise for 2D − 1 cycles.
- R10: A new duty value takes effect in the generator only when its counter is at 0 or 255. The value is therefore in force on pwmOut no more than 257 cycles after dutyValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| servoIn | input | 1 | Asynchronous servo pulse input |
| pwmOut | output | 1 | Proportional PWM output |
| dutyOut | output | 8 | Latest computed duty value (debug) |
| dutyValid | output | 1 | One-cycle strobe marking a new dutyOut |

## Verification
A wrong width count or a wrong clamp bound shows up as a wrong dutyOut at the dutyValid strobe, one divider run after the falling edge. A stuck measurement state shows up as a missing or an extra strobe. An edge detector that is not masked while the duty is converted shows up as a second strobe, carrying duty 0, a few tens of cycles after the first. A compare register that is loaded badly, or loaded at the wrong moment, changes the high-cycle count of pwmOut over a 510-cycle window that starts no later than 257 cycles after the strobe.

// File: rtl/servo_pwm_pkg.sv
`timescale 1ns/1ps
package servo_pwm_pkg;

  localparam int DUTY_W = 8;

  typedef struct packed {
    logic clearCnt;   // restart width counter and prescaler
    logic countEn;    // pulse is being timed
    logic startDiv;   // capture clamped width, start divider
    logic loadDuty;   // publish quotient as new duty
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_ARMED,
    ST_MEASURE,
    ST_DIVIDE,
    ST_LOAD
  } ctrlState_t;

endpackage

// File: rtl/servo_pwm_ctrl.sv
`timescale 1ns/1ps
module servo_pwm_ctrl
  import servo_pwm_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         servoIn,
  input  logic         satHit,
  input  logic         divBusy,
  output ctrlStrobes_t strobes
);

  logic syncA, syncB, prevLvl;
  logic riseSeen, fallSeen;
  ctrlState_t state, stateNext;

  // two-flop synchroniser plus edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      syncA   <= servoIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  assign riseSeen = syncB & ~prevLvl;
  assign fallSeen = ~syncB & prevLvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ARMED;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_ARMED: begin
        if (riseSeen) begin
          strobes.clearCnt = 1'b1;
          stateNext        = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        strobes.countEn = 1'b1;
        if (satHit) begin
          stateNext = ST_ARMED;          // over-long pulse: drop it
        end else if (fallSeen) begin
          strobes.startDiv = 1'b1;
          stateNext        = ST_DIVIDE;
        end
      end
      ST_DIVIDE: begin
        if (!divBusy) stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        strobes.loadDuty = 1'b1;
        stateNext        = ST_ARMED;
      end
      default: stateNext = ST_ARMED;
    endcase
  end

endmodule

// File: rtl/servo_pwm_dp.sv
`timescale 1ns/1ps
module servo_pwm_dp
  import servo_pwm_pkg::*;
#(
  parameter int TICK_DIV  = 16,
  parameter int MIN_TICKS = 57,
  parameter int MAX_TICKS = 132,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  output logic              satHit,
  output logic              divBusy,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              dutyValid
);

  localparam int NUM_W  = CNT_W + DUTY_W;
  localparam int BITC_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_TICKS);
  localparam logic [CNT_W-1:0] SAT_V = '1;
  localparam logic [CNT_W:0]   DEN_V = (CNT_W+1)'(MAX_TICKS - MIN_TICKS);

  logic             tick;
  logic [CNT_W-1:0] widthCnt, widthNext, widthClamp, widthDiff;
  logic [NUM_W-1:0] numInit, numQ;
  logic [CNT_W-1:0] rem;
  logic [CNT_W:0]   remShift, remSub;
  logic             remGe;
  logic [BITC_W-1:0] bitCnt;

  // prescaler: a variant with no divider when one clock is one tick
  generate
    if (TICK_DIV == 1) begin : g_noPre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] preCnt;
      assign tick = (preCnt == PRE_W'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                preCnt <= '0;
        else if (strobes.clearCnt) preCnt <= '0;
        else if (strobes.countEn)  preCnt <= tick ? '0 : preCnt + 1'b1;
      end
    end
  endgenerate

  // width counter, saturating
  assign widthNext = (tick && widthCnt != SAT_V) ? widthCnt + 1'b1 : widthCnt;
  assign satHit    = (widthNext == SAT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                widthCnt <= '0;
    else if (strobes.clearCnt) widthCnt <= '0;
    else if (strobes.countEn)  widthCnt <= widthNext;
  end

  // clamp to the legal window and form (w - min) * 255
  always_comb begin
    if (widthNext < MIN_V)      widthClamp = MIN_V;
    else if (widthNext > MAX_V) widthClamp = MAX_V;
    else                        widthClamp = widthNext;
  end

  assign widthDiff = widthClamp - MIN_V;
  assign numInit   = ({{DUTY_W{1'b0}}, widthDiff} << DUTY_W)
                   - {{DUTY_W{1'b0}}, widthDiff};

  // restoring divider, one quotient bit per cycle
  assign remShift = {rem, numQ[NUM_W-1]};
  assign remGe    = (remShift >= DEN_V);
  assign remSub   = remShift - DEN_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      numQ    <= '0;
      rem     <= '0;
      bitCnt  <= '0;
      divBusy <= 1'b0;
    end else if (strobes.startDiv) begin
      numQ    <= numInit;
      rem     <= '0;
      bitCnt  <= BITC_W'(NUM_W);
      divBusy <= 1'b1;
    end else if (divBusy) begin
      numQ   <= {numQ[NUM_W-2:0], remGe};
      rem    <= remGe ? remSub[CNT_W-1:0] : remShift[CNT_W-1:0];
      bitCnt <= bitCnt - 1'b1;
      if (bitCnt == BITC_W'(1)) divBusy <= 1'b0;
    end
  end

  // publish duty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dutyOut   <= '0;
      dutyValid <= 1'b0;
    end else begin
      dutyValid <= strobes.loadDuty;
      if (strobes.loadDuty) dutyOut <= numQ[DUTY_W-1:0];
    end
  end

endmodule

// File: rtl/servo_pwm_gen.sv
`timescale 1ns/1ps
module servo_pwm_gen
  import servo_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] dutyIn,
  input  logic              dutyLoad,
  output logic [DUTY_W-1:0] pwmCnt,
  output logic [DUTY_W-1:0] cmpVal,
  output logic              pwmOut
);

  localparam logic [DUTY_W-1:0] TOP_V = '1;

  logic              dirUp;
  logic [DUTY_W-1:0] shadowVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwmCnt <= '0;
      dirUp  <= 1'b1;
    end else if (dirUp) begin
      pwmCnt <= pwmCnt + 1'b1;
      if (pwmCnt == TOP_V - 1'b1) dirUp <= 1'b0;
    end else begin
      pwmCnt <= pwmCnt - 1'b1;
      if (pwmCnt == DUTY_W'(1)) dirUp <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowVal <= '0;
      cmpVal    <= '0;
      pwmOut    <= 1'b0;
    end else begin
      if (dutyLoad) shadowVal <= dutyIn;
      if (pwmCnt == TOP_V || pwmCnt == '0) cmpVal <= shadowVal;
      pwmOut <= (cmpVal == TOP_V) || (pwmCnt < cmpVal);
    end
  end

endmodule

// File: rtl/servo_pwm_top.sv
`timescale 1ns/1ps
module servo_pwm_top
  import servo_pwm_pkg::*;
#(
  parameter int TICK_DIV  = 16,
  parameter int MIN_TICKS = 57,
  parameter int MAX_TICKS = 132,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              servoIn,
  output logic              pwmOut,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              dutyValid
);

  ctrlStrobes_t      strobes;
  logic              satHit;
  logic              divBusy;
  logic [DUTY_W-1:0] pwmCnt;
  logic [DUTY_W-1:0] cmpVal;

  servo_pwm_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .servoIn (servoIn),
    .satHit  (satHit),
    .divBusy (divBusy),
    .strobes (strobes)
  );

  servo_pwm_dp #(
    .TICK_DIV  (TICK_DIV),
    .MIN_TICKS (MIN_TICKS),
    .MAX_TICKS (MAX_TICKS),
    .CNT_W     (CNT_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .satHit    (satHit),
    .divBusy   (divBusy),
    .dutyOut   (dutyOut),
    .dutyValid (dutyValid)
  );

  servo_pwm_gen gen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dutyIn   (dutyOut),
    .dutyLoad (dutyValid),
    .pwmCnt   (pwmCnt),
    .cmpVal   (cmpVal),
    .pwmOut   (pwmOut)
  );

endmodule

// File: rtl/servo_pwm_chk.sv
`timescale 1ns/1ps
module servo_pwm_chk
  import servo_pwm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwmOut,
  input logic [DUTY_W-1:0] dutyOut,
  input logic              dutyValid,
  input ctrlStrobes_t      strobes,
  input logic              satHit,
  input logic              divBusy,
  input logic [DUTY_W-1:0] pwmCnt,
  input logic [DUTY_W-1:0] cmpVal
);

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dutyValid |=> !dutyValid);

  p_duty_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dutyValid |-> $stable(dutyOut));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    divBusy |-> !strobes.clearCnt);

  p_sat_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.countEn && satHit) |=> !divBusy);

  p_pwm_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpVal == '0) |=> !pwmOut);

  p_pwm_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpVal == '1) |=> pwmOut);

  p_cmp_turn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmpVal) |-> ($past(pwmCnt) == '0 || $past(pwmCnt) == '1));

endmodule

bind servo_pwm_top servo_pwm_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwmOut    (pwmOut),
  .dutyOut   (dutyOut),
  .dutyValid (dutyValid),
  .strobes   (strobes),
  .satHit    (satHit),
  .divBusy   (divBusy),
  .pwmCnt    (pwmCnt),
  .cmpVal    (cmpVal)
);

// File: tb/servo_pwm_top_tb_top.sv
`timescale 1ns/1ps
module servo_pwm_top_tb_top;

  localparam int TD   = 2;
  localparam int MINT = 57;
  localparam int MAXT = 132;
  localparam int CW   = 8;
  localparam int NVEC = 8;

  // {high cycles, expected duty}; width = cycles / 2
  localparam int VEC [NVEC][2] = '{
    '{100, 0},   // w 50  below window
    '{114, 0},   // w 57  at minimum
    '{116, 3},   // w 58
    '{151, 61},  // w 75  odd cycle count, floor
    '{190, 129}, // w 95
    '{262, 251}, // w 131
    '{264, 255}, // w 132 at maximum
    '{400, 255}  // w 200 above window
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       servoIn = 1'b0;
  logic       pwmOut;
  logic [7:0] dutyOut;
  logic       dutyValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  servo_pwm_top #(
    .TICK_DIV (TD), .MIN_TICKS (MINT), .MAX_TICKS (MAXT), .CNT_W (CW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .servoIn (servoIn),
    .pwmOut (pwmOut), .dutyOut (dutyOut), .dutyValid (dutyValid)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pwmHighExp(input int d);
    if (d == 0)   return 0;
    if (d == 255) return 510;
    return 2 * d - 1;
  endfunction

  task automatic sendPulse(input int n);
    @(negedge clk);
    servoIn = 1'b1;
    repeat (n) @(negedge clk);
    servoIn = 1'b0;
  endtask

  task automatic waitValid(input int limit, output int seen, output int val);
    seen = 0;
    val  = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (dutyValid) begin
        seen = 1;
        val  = dutyOut;
        break;
      end
    end
  endtask

  task automatic countHigh(output int hi);
    hi = 0;
    for (int i = 0; i < 510; i++) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seen, val, hi, nValid, lastVal;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 dutyOut", dutyOut, 0);
    check("R1 dutyValid", dutyValid, 0);
    rst_n = 1'b1;
    countHigh(hi);
    check("R1 pwmOut low", hi, 0);

    // vector table: R2, R3, R4, R5, R6, R9, R10
    for (int v = 0; v < NVEC; v++) begin
      sendPulse(VEC[v][0]);
      waitValid(200, seen, val);
      check("R6 strobe seen", seen, 1);
      check("R2,R3,R4,R5 duty", val, VEC[v][1]);
      @(negedge clk);
      check("R6 strobe one cycle", dutyValid, 0);
      repeat (270) @(negedge clk);
      countHigh(hi);
      check("R9,R10 pwm high cycles", hi, pwmHighExp(VEC[v][1]));
      repeat (20) @(negedge clk);
    end

    // R7: a pulse while the duty is converted is ignored
    sendPulse(190);
    waitValid(200, seen, val);
    check("R7 setup duty", val, 129);
    repeat (30) @(negedge clk);
    sendPulse(264);
    nValid = 0;
    lastVal = -1;
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      if (i == 4)  servoIn = 1'b1;
      if (i == 10) servoIn = 1'b0;
      if (dutyValid) begin
        nValid++;
        lastVal = dutyOut;
      end
    end
    check("R7 single strobe", nValid, 1);
    check("R7 duty kept", lastVal, 255);
    check("R7 dutyOut after", dutyOut, 255);

    // R8: saturated pulse is discarded
    sendPulse(600);
    waitValid(800, seen, val);
    check("R8 no strobe", seen, 0);
    check("R8 dutyOut kept", dutyOut, 255);
    countHigh(hi);
    check("R8 pwm unchanged", hi, 510);

    // R8: block re-arms after a discard
    repeat (20) @(negedge clk);
    sendPulse(190);
    waitValid(200, seen, val);
    check("R8 re-armed duty", val, 129);
    repeat (270) @(negedge clk);
    countHigh(hi);
    check("R10 pwm after reload", hi, pwmHighExp(129));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule